// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block hands empty receive buffers to an incoming-frame data mover. Buffers are described by a ring of 8-byte descriptors in memory. When a frame begins, the block reads the descriptor at its ring pointer. If the empty flag shows that hardware owns the descriptor, the block offers the buffer address to the mover, together with one buffer length that applies to every buffer. When the mover reports that the buffer is full, or that the frame has ended, the block writes the descriptor back, clears the empty flag and steps the pointer. A descriptor whose wrap flag is set returns the pointer to the ring start.

The length of a frame is unknown before it arrives, so one frame may use several descriptors. Every descriptor except the last of a frame records the full buffer length. The last one records the actual byte count and gets the last flag. Software sets the ring start and the buffer size through a small write port before it raises the enable. Dropping the enable returns the pointer to the ring start. It never touches the descriptors in memory.

Top module: `rx_desc_ring`

## Requirements
- R1: While reset is active and after it is released, `buf_valid`, `desc_rd_req`, `desc_wr_req` and `no_buf` are low.
- R2: Descriptor layout, 64 bits: bit 63 is empty (1 = owned by hardware), bit 62 is wrap, bit 61 is last, bits 47:32 are the length and bits 31:0 are the buffer address. While the block is enabled and idle, a pulse on `frame_start` causes the following:
  - `desc_rd_req` goes high for one cycle, with `desc_addr` at the ring pointer.
  - Three cycles after `frame_start`, `buf_valid` is high, with `buf_addr` taken from the descriptor.
- R3: `buf_len` equals the buffer-size register with its lowest 4 bits forced to zero. The register is written with `cfg_sel`=1.
- R4: The ring start register is written with `cfg_sel`=0. Its lowest 2 bits are ignored, so every descriptor address is 4-byte aligned.
- R5: If the fetched descriptor has empty=0, `no_buf` pulses for one cycle and the frame is dropped. There is no write-back and the pointer does not move.
- R6: One cycle after `buf_done` with `buf_last`=0, `desc_wr_req` is high at the same address. The data written has empty=0, last=0 and length equal to the buffer length. The wrap flag and the buffer address are kept.
- R7: When `buf_done` comes with `buf_last`=1, the write-back has last=1 and length equal to `buf_count`, and the block returns to idle.
- R8: After a write-back the pointer moves on by 8 bytes. A frame that is not finished fetches the next descriptor with no new `frame_start`.
- R9: After writing back a descriptor whose wrap flag is set, the next fetch uses the ring start address.
- R10: While `enable` is low:
  - the pointer is reloaded with the ring start;
  - no descriptor is read or written, and `frame_start` is ignored;
  - a buffer in progress is abandoned without write-back.
- R11: If a frame needs another descriptor and that descriptor has empty=0, `no_buf` pulses and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low resets the pointer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = ring start, 1 = buffer size |
| cfg_wdata | input | 32 | Configuration write data |
| frame_start | input | 1 | A new frame is arriving |
| desc_rd_req | output | 1 | Descriptor read request (one cycle) |
| desc_addr | output | 32 | Descriptor address for reads and writes |
| desc_rd_valid | input | 1 | Read data valid |
| desc_rd_data | input | 64 | Descriptor read data |
| desc_wr_req | output | 1 | Descriptor write-back strobe |
| desc_wr_data | output | 64 | Descriptor write-back data |
| buf_valid | output | 1 | A buffer is offered to the mover |
| buf_addr | output | 32 | Buffer start address |
| buf_len | output | 16 | Buffer length in bytes |
| buf_done | input | 1 | Mover finished the offered buffer |
| buf_last | input | 1 | That buffer ends the frame |
| buf_count | input | 16 | Bytes in the final buffer |
| no_buf | output | 1 | One-cycle pulse: no empty descriptor, frame dropped |

## Verification
Counting from the clock edge that samples `frame_start` or a write-back:
- The descriptor read request is visible in the next cycle.
- A buffer offer or a `no_buf` pulse follows two edges later, when the memory model answers a read one cycle after the request.
- `desc_wr_req` is high in the cycle after `buf_done` is sampled. The descriptor in memory is updated at the edge that ends that cycle.

The bench drives every input on the falling edge. It steps a fixed number of falling edges between a stimulus and its check, so each check lands in the exact cycle the result is due. It never waits for a result to appear.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int RXR_ADDR_W     = 32;
  localparam int RXR_LEN_W      = 16;
  localparam int RXR_DESC_W     = 64;
  localparam int RXR_DESC_BYTES = 8;
  localparam int RXR_RSVD_W     = RXR_DESC_W - 3 - RXR_LEN_W - RXR_ADDR_W;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_GRANT = 3'd3,
    ST_WB    = 3'd4
  } rxr_state_e;

  typedef struct packed {
    logic                   empty;
    logic                   wrap;
    logic                   last;
    logic [RXR_RSVD_W-1:0]  rsvd;
    logic [RXR_LEN_W-1:0]   len;
    logic [RXR_ADDR_W-1:0]  addr;
  } rxr_desc_t;

endpackage

// File: rtl/rxr_rst_sync.sv
module rxr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs #(
  parameter int ADDR_W      = rxr_pkg::RXR_ADDR_W,
  parameter int LEN_W       = rxr_pkg::RXR_LEN_W,
  parameter int BASE_ALIGN  = 2,
  parameter int SIZE_ALIGN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] ring_base,
  output logic [LEN_W-1:0]  buf_size
);

  localparam int BASE_KEEP = ADDR_W - BASE_ALIGN;
  localparam int SIZE_KEEP = LEN_W - SIZE_ALIGN;

  logic [BASE_KEEP-1:0] base_q, base_d;
  logic [SIZE_KEEP-1:0] size_q, size_d;
  logic                 base_en, size_en;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[BASE_ALIGN-1:0], cfg_wdata[ADDR_W-1:LEN_W],
                             cfg_wdata[SIZE_ALIGN-1:0]};

  always_comb begin
    base_en = cfg_we && !cfg_sel;
    size_en = cfg_we &&  cfg_sel;
    base_d  = cfg_wdata[ADDR_W-1:BASE_ALIGN];
    size_d  = cfg_wdata[LEN_W-1:SIZE_ALIGN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      if (size_en) size_q <= size_d;
    end
  end

  assign ring_base = {base_q, {BASE_ALIGN{1'b0}}};
  assign buf_size  = {size_q, {SIZE_ALIGN{1'b0}}};

endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int ADDR_W     = rxr_pkg::RXR_ADDR_W,
  parameter int DESC_BYTES = rxr_pkg::RXR_DESC_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              adv,
  input  logic              wrap,
  output logic [ADDR_W-1:0] ptr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;

  always_comb begin
    ptr_en = !enable || adv;
    if (!enable)   ptr_d = ring_base;
    else if (wrap) ptr_d = ring_base;
    else           ptr_d = ptr_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int ADDR_W = RXR_ADDR_W,
  parameter int LEN_W  = RXR_LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              frame_start,
  input  logic              rd_valid,
  input  rxr_desc_t         rd_desc,
  input  logic              buf_done,
  input  logic              buf_last,
  input  logic [LEN_W-1:0]  buf_count,
  input  logic [LEN_W-1:0]  buf_size,
  output logic              rd_req,
  output logic              wr_req,
  output rxr_desc_t         wr_desc,
  output logic              buf_valid,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [LEN_W-1:0]  buf_len,
  output logic              no_buf,
  output logic              ptr_adv,
  output logic              ptr_wrap
);

  rxr_state_e         st_q, st_d;
  rxr_desc_t          desc_q;
  logic               desc_ld;
  logic               wb_last_q, wb_last_d;
  logic [LEN_W-1:0]   wb_len_q, wb_len_d;
  logic               wb_ld;
  logic               no_buf_q, no_buf_d;

  always_comb begin
    st_d      = st_q;
    desc_ld   = 1'b0;
    wb_ld     = 1'b0;
    no_buf_d  = 1'b0;
    wb_last_d = buf_last;
    wb_len_d  = buf_last ? buf_count : buf_size;
    if (!enable) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  if (frame_start) st_d = ST_REQ;
        ST_REQ:   st_d = ST_WAIT;
        ST_WAIT: begin
          if (rd_valid) begin
            desc_ld = 1'b1;
            if (rd_desc.empty) begin
              st_d = ST_GRANT;
            end else begin
              st_d     = ST_IDLE;
              no_buf_d = 1'b1;
            end
          end
        end
        ST_GRANT: begin
          if (buf_done) begin
            wb_ld = 1'b1;
            st_d  = ST_WB;
          end
        end
        ST_WB:    st_d = wb_last_q ? ST_IDLE : ST_REQ;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      no_buf_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      no_buf_q <= no_buf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (desc_ld) desc_q <= rd_desc;
    if (wb_ld) begin
      wb_last_q <= wb_last_d;
      wb_len_q  <= wb_len_d;
    end
  end

  logic unused_desc_last;
  assign unused_desc_last = desc_q.last;

  always_comb begin
    rd_req        = enable && (st_q == ST_REQ);
    buf_valid     = enable && (st_q == ST_GRANT);
    wr_req        = enable && (st_q == ST_WB);
    buf_addr      = desc_q.addr;
    buf_len       = buf_size;
    no_buf        = no_buf_q;
    ptr_adv       = wr_req;
    ptr_wrap      = desc_q.wrap;
    wr_desc       = desc_q;
    wr_desc.empty = 1'b0;
    wr_desc.last  = wb_last_q;
    wr_desc.len   = wb_len_q;
  end

endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxr_pkg::*;
#(
  parameter int ADDR_W = RXR_ADDR_W,
  parameter int LEN_W  = RXR_LEN_W,
  parameter int DESC_W = RXR_DESC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              frame_start,
  output logic              desc_rd_req,
  output logic [ADDR_W-1:0] desc_addr,
  input  logic              desc_rd_valid,
  input  logic [DESC_W-1:0] desc_rd_data,
  output logic              desc_wr_req,
  output logic [DESC_W-1:0] desc_wr_data,
  output logic              buf_valid,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [LEN_W-1:0]  buf_len,
  input  logic              buf_done,
  input  logic              buf_last,
  input  logic [LEN_W-1:0]  buf_count,
  output logic              no_buf
);

  logic              rst_i_n;
  logic [ADDR_W-1:0] ring_base;
  logic [LEN_W-1:0]  buf_size;
  logic              ptr_adv, ptr_wrap;
  rxr_desc_t         rd_desc, wr_desc;

  assign rd_desc      = rxr_desc_t'(desc_rd_data);
  assign desc_wr_data = DESC_W'(wr_desc);

  rxr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  rxr_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .ring_base (ring_base),
    .buf_size  (buf_size)
  );

  rxr_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .enable    (enable),
    .ring_base (ring_base),
    .adv       (ptr_adv),
    .wrap      (ptr_wrap),
    .ptr       (desc_addr)
  );

  rxr_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .enable      (enable),
    .frame_start (frame_start),
    .rd_valid    (desc_rd_valid),
    .rd_desc     (rd_desc),
    .buf_done    (buf_done),
    .buf_last    (buf_last),
    .buf_count   (buf_count),
    .buf_size    (buf_size),
    .rd_req      (desc_rd_req),
    .wr_req      (desc_wr_req),
    .wr_desc     (wr_desc),
    .buf_valid   (buf_valid),
    .buf_addr    (buf_addr),
    .buf_len     (buf_len),
    .no_buf      (no_buf),
    .ptr_adv     (ptr_adv),
    .ptr_wrap    (ptr_wrap)
  );

endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DESC_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              frame_start,
  input logic              desc_rd_req,
  input logic [ADDR_W-1:0] desc_addr,
  input logic              desc_wr_req,
  input logic [DESC_W-1:0] desc_wr_data,
  input logic              buf_valid,
  input logic [LEN_W-1:0]  buf_len,
  input logic              buf_done,
  input logic              no_buf
);

  // R2: a read request lasts exactly one cycle
  a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    desc_rd_req |=> !desc_rd_req);

  // R3: offered length is a multiple of 16
  a_r3_len_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> (buf_len[3:0] == 4'h0));

  // R4: descriptor addresses are word aligned
  a_r4_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_rd_req || desc_wr_req) |-> (desc_addr[1:0] == 2'b00));

  // R5: a dropped frame neither offers a buffer nor writes back
  a_r5_nobuf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    no_buf |-> (!buf_valid && !desc_wr_req));

  // R5: the no-buffer indication is a single-cycle pulse
  a_r5_nobuf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    no_buf |=> !no_buf);

  // R6: a write-back follows a completed offer and clears ownership
  a_r6_wb_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_req |-> $past(buf_valid && buf_done));

  a_r6_wb_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_req |-> !desc_wr_data[DESC_W-1]);

  // R10: disabling ends any buffer offer and descriptor traffic
  a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!buf_valid && !desc_rd_req && !desc_wr_req));

  // R10: a frame start while disabled causes no read
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && frame_start) |=> !desc_rd_req);

endmodule

bind rx_desc_ring rx_desc_ring_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DESC_W(DESC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .frame_start  (frame_start),
  .desc_rd_req  (desc_rd_req),
  .desc_addr    (desc_addr),
  .desc_wr_req  (desc_wr_req),
  .desc_wr_data (desc_wr_data),
  .buf_valid    (buf_valid),
  .buf_len      (buf_len),
  .buf_done     (buf_done),
  .no_buf       (no_buf)
);

// File: tb/rx_desc_ring_bench.sv
module rx_desc_ring_bench;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic        cfg_we;
  logic        cfg_sel;
  logic [31:0] cfg_wdata;
  logic        frame_start;
  logic        desc_rd_req;
  logic [31:0] desc_addr;
  logic        desc_rd_valid;
  logic [63:0] desc_rd_data;
  logic        desc_wr_req;
  logic [63:0] desc_wr_data;
  logic        buf_valid;
  logic [31:0] buf_addr;
  logic [15:0] buf_len;
  logic        buf_done;
  logic        buf_last;
  logic [15:0] buf_count;
  logic        no_buf;

  int checks;
  int errors;
  int cycles;

  logic [63:0] mem [16];

  rx_desc_ring u_rx_desc_ring (
    .clk (clk), .rst_n (rst_n), .enable (enable),
    .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_wdata (cfg_wdata),
    .frame_start (frame_start),
    .desc_rd_req (desc_rd_req), .desc_addr (desc_addr),
    .desc_rd_valid (desc_rd_valid), .desc_rd_data (desc_rd_data),
    .desc_wr_req (desc_wr_req), .desc_wr_data (desc_wr_data),
    .buf_valid (buf_valid), .buf_addr (buf_addr), .buf_len (buf_len),
    .buf_done (buf_done), .buf_last (buf_last), .buf_count (buf_count),
    .no_buf (no_buf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // descriptor memory model: read answered one cycle after the request
  always @(posedge clk) begin
    desc_rd_valid <= desc_rd_req;
    if (desc_rd_req) desc_rd_data <= mem[desc_addr[6:3]];
    if (desc_wr_req) mem[desc_addr[6:3]] <= desc_wr_data;
  end

  function automatic logic [63:0] mk(input logic e, input logic w, input logic l,
                                     input logic [15:0] len, input logic [31:0] a);
    return {e, w, l, 13'h0, len, a};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic sel, input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  // call in the cycle the read request is due; returns in the offer cycle
  task automatic expect_fetch(input logic [31:0] a, input string req);
    chk(desc_rd_req === 1'b1 && desc_addr === a, req, {desc_rd_req, desc_addr}, {1'b1, a});
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_offer(input logic [31:0] a, input logic [15:0] len, input string req);
    chk(buf_valid === 1'b1 && buf_addr === a, req, {buf_valid, buf_addr}, {1'b1, a});
    chk(buf_len === len, "R3 length", buf_len, len);
  endtask

  // completes the offered buffer; returns after the write-back edge
  task automatic finish_buf(input logic last, input logic [15:0] cnt);
    buf_done = 1'b1; buf_last = last; buf_count = cnt;
    @(negedge clk); buf_done = 1'b0;
    chk(desc_wr_req === 1'b1, "R6 write-back strobe", desc_wr_req, 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!buf_valid && !desc_rd_req && !desc_wr_req && !no_buf, "R1 reset outputs",
        {buf_valid, desc_rd_req, desc_wr_req, no_buf}, 0);
  endtask

  task automatic t_single();
    pulse_start();
    expect_fetch(32'h1000, "R4 aligned start fetch");
    expect_offer(32'h2000, 16'h0050, "R2 offer");
    finish_buf(1'b1, 16'h002A);
    chk(mem[0] === mk(0, 0, 1, 16'h002A, 32'h2000), "R7 final write-back", mem[0],
        mk(0, 0, 1, 16'h002A, 32'h2000));
    chk(desc_rd_req === 1'b0, "R7 idle after last", desc_rd_req, 0);
  endtask

  task automatic t_multi_wrap();
    pulse_start();
    expect_fetch(32'h1008, "R8 step by 8");
    expect_offer(32'h3000, 16'h0050, "R2 second buffer");
    finish_buf(1'b0, 16'h0000);
    chk(mem[1] === mk(0, 0, 0, 16'h0050, 32'h3000), "R6 middle write-back", mem[1],
        mk(0, 0, 0, 16'h0050, 32'h3000));
    expect_fetch(32'h1010, "R8 automatic next fetch");
    expect_offer(32'h4000, 16'h0050, "R8 continued offer");
    finish_buf(1'b1, 16'h0007);
    chk(mem[2] === mk(0, 1, 1, 16'h0007, 32'h4000), "R9 wrap kept in write-back", mem[2],
        mk(0, 1, 1, 16'h0007, 32'h4000));
  endtask

  task automatic t_no_buffer();
    pulse_start();
    expect_fetch(32'h1000, "R9 wrap to ring start");
    chk(no_buf === 1'b1 && buf_valid === 1'b0, "R5 no buffer pulse", {no_buf, buf_valid}, 2'b10);
    @(negedge clk);
    chk(no_buf === 1'b0 && desc_wr_req === 1'b0, "R5 pulse ends, no write", {no_buf, desc_wr_req}, 0);
    mem[0] = mk(1, 0, 0, 16'h0, 32'h5000);
    pulse_start();
    expect_fetch(32'h1000, "R5 pointer held");
    expect_offer(32'h5000, 16'h0050, "R5 retry offer");
    finish_buf(1'b1, 16'h0011);
  endtask

  task automatic t_mid_frame();
    mem[1] = mk(1, 0, 0, 16'h0, 32'h6000);
    pulse_start();
    expect_fetch(32'h1008, "R11 first fetch");
    expect_offer(32'h6000, 16'h0050, "R11 first offer");
    finish_buf(1'b0, 16'h0000);
    expect_fetch(32'h1010, "R11 second fetch");
    chk(no_buf === 1'b1, "R11 no buffer mid frame", no_buf, 1);
    repeat (2) @(negedge clk);
    chk(desc_rd_req === 1'b0 && buf_valid === 1'b0, "R11 back to idle",
        {desc_rd_req, buf_valid}, 0);
  endtask

  task automatic t_disable();
    mem[2] = mk(1, 1, 0, 16'h0, 32'h7000);
    mem[0] = mk(1, 0, 0, 16'h0, 32'h8000);
    pulse_start();
    expect_fetch(32'h1010, "R10 fetch before disable");
    expect_offer(32'h7000, 16'h0050, "R10 offer before disable");
    enable = 1'b0;
    @(negedge clk);
    chk(buf_valid === 1'b0, "R10 offer abandoned", buf_valid, 0);
    frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    chk(desc_rd_req === 1'b0 && desc_wr_req === 1'b0, "R10 no traffic while disabled",
        {desc_rd_req, desc_wr_req}, 0);
    @(negedge clk);
    chk(desc_rd_req === 1'b0, "R10 start ignored", desc_rd_req, 0);
    chk(mem[2] === mk(1, 1, 0, 16'h0, 32'h7000), "R10 descriptor untouched", mem[2],
        mk(1, 1, 0, 16'h0, 32'h7000));
    enable = 1'b1;
    pulse_start();
    expect_fetch(32'h1000, "R10 pointer back to start");
    expect_offer(32'h8000, 16'h0050, "R10 offer after enable");
    finish_buf(1'b1, 16'h0010);
    chk(mem[0] === mk(0, 0, 1, 16'h0010, 32'h8000), "R7 write-back after enable", mem[0],
        mk(0, 0, 1, 16'h0010, 32'h8000));
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=below 20000", cycles);
      summary();
    end
  end

  initial begin
    checks = 0; errors = 0; cycles = 0;
    rst_n = 1'b0; enable = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    frame_start = 1'b0; buf_done = 1'b0; buf_last = 1'b0; buf_count = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem[0] = mk(1, 0, 0, 16'h0, 32'h2000);
    mem[1] = mk(1, 0, 0, 16'h0, 32'h3000);
    mem[2] = mk(1, 1, 0, 16'h0, 32'h4000);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    cfg(1'b0, 32'h0000_1003);
    cfg(1'b1, 32'h0000_005F);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_multi_wrap();
    t_no_buffer();
    t_mid_frame();
    t_disable();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule